// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Core

This block is a clocked model of a 512-word by 8-bit static memory in which every word has a shadow nonvolatile copy. A host drives it through four active-low strobes (chip select, output enable, write enable and nonvolatile select), a 9-bit address and a split data bus: `dq_i` in, `dq_o` out, and `dq_oe` as the tri-state enable. All of these are sampled on the rising edge of `clk`. With the nonvolatile select high, the block behaves as an ordinary byte-wide RAM. Reads return the addressed byte one clock after the request is sampled.

With the nonvolatile select low, the block starts a bulk transfer between the two arrays. A STORE copies the working array into the shadow array. A RECALL first clears the working array and then reloads it from the shadow array, which it leaves untouched. The array is held as 16 rows of 32 bytes: the upper four address bits pick the row and the lower five pick the byte. A sequencer moves one row per step and raises `busy` for the whole transfer. While `busy` is high, the bus is shut out.

The long transfer times become clock-count parameters, with one count per row step for each direction. After reset deasserts, a RECALL runs automatically before the first bus access is accepted.

Top module: `nvsram_core`

## Requirements
- R1: The working array holds 512 distinct 8-bit words; all 9 address bits are decoded, so addresses that differ only in bit 8 or only in bit 5 hold independent bytes.
- R2: When a clock edge samples `ce_n`=0, `oe_n`=0, `we_n`=1, `nv_n`=1 and `busy`=0, then after that edge `dq_oe`=1 and `dq_o` holds the byte at `addr`.
- R3: `dq_oe` is 0 after any edge that did not sample a read as in R2. This covers `ce_n`=1, `oe_n`=1 with `we_n`=1, and a write.
- R4: When an edge samples `ce_n`=0, `we_n`=0, `nv_n`=1 and `busy`=0, `dq_i` is written to the word at `addr` whatever the level of `oe_n`.
- R5: When an edge samples `ce_n`=0, `nv_n`=0, `we_n`=0 and `busy`=0, a STORE copies every working word to the shadow array. `busy` is then high for exactly 16*STORE_ROW_CYC cycles, starting after that edge.
- R6: While `busy` is high, reads and writes are ignored and `dq_oe` stays 0.
- R7: When an edge samples `ce_n`=0, `nv_n`=0, `we_n`=1, `oe_n`=0 and `busy`=0, a RECALL runs with `busy` high for exactly 32*RECALL_ROW_CYC cycles. Afterwards every working word equals its shadow word, and the shadow array is unchanged, so a second RECALL gives the same contents.
- R8: A STORE request made during a RECALL, or a RECALL request made during a STORE, is ignored. It neither lengthens the running transfer nor changes the shadow array.
- R9: During reset and until the automatic RECALL that follows it completes, `busy` is 1 and no read is answered. After it completes, the working array holds the shadow contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile transfer select, active low |
| addr | input | 9 | Word address: bits 8..5 row, bits 4..0 byte in row |
| dq_i | input | 8 | Write data from the bus |
| dq_o | output | 8 | Read data to the bus |
| dq_oe | output | 1 | Drive enable for the data bus; 0 means high impedance |
| busy | output | 1 | High while a STORE or RECALL is in progress |

## Verification
The assertions assume that the host changes the strobes and address only between clock edges, so that every edge sees one settled command. They also assume that a transfer request and a plain read are never decoded from the same sample, because `nv_n` separates them. The bench drives every input on the falling edge and holds it across the following rising edge. It deliberately keeps issuing reads, writes and opposite-direction requests while `busy` is high, so that the lockout and length checks see real traffic instead of an idle bus.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STORE = 2'd1,
    SEQ_CLEAR = 2'd2,
    SEQ_LOAD  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/nvsram_cells.sv
module nvsram_cells
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  seq_state_e        state,
  input  logic              row_fire,
  input  logic [ADDR_W-COL_W-1:0] row_sel
);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int ROWS     = 2 ** ROW_W;
  localparam int ROW_BITS = (2 ** COL_W) * DATA_W;

  logic [ROW_BITS-1:0] work_q [ROWS];
  logic [ROW_BITS-1:0] shadow_q [ROWS];

  logic [ROW_W-1:0] wr_row, rd_row;
  logic [COL_W-1:0] wr_col, rd_col;

  assign wr_row = wr_addr[ADDR_W-1:COL_W];
  assign wr_col = wr_addr[COL_W-1:0];
  assign rd_row = rd_addr[ADDR_W-1:COL_W];
  assign rd_col = rd_addr[COL_W-1:0];

  assign rd_data = work_q[rd_row][int'(rd_col)*DATA_W +: DATA_W];

  // Working array: row clear, row load, or byte write
  always_ff @(posedge clk) begin
    if (row_fire && state == SEQ_CLEAR) begin
      work_q[row_sel] <= '0;
    end else if (row_fire && state == SEQ_LOAD) begin
      work_q[row_sel] <= shadow_q[row_sel];
    end else if (wr_en) begin
      work_q[wr_row][int'(wr_col)*DATA_W +: DATA_W] <= wr_data;
    end
  end

  // Shadow array: written only by the STORE steps
  always_ff @(posedge clk) begin
    if (row_fire && state == SEQ_STORE) begin
      shadow_q[row_sel] <= work_q[row_sel];
    end
  end
endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int ROW_W          = 4,
  parameter int STORE_ROW_CYC  = 64,
  parameter int RECALL_ROW_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_req,
  input  logic             recall_req,
  output seq_state_e       state,
  output logic             row_fire,
  output logic [ROW_W-1:0] row_sel,
  output logic             busy
);
  localparam int MAX_CYC = (STORE_ROW_CYC > RECALL_ROW_CYC) ? STORE_ROW_CYC : RECALL_ROW_CYC;
  localparam int TICK_W  = $clog2(MAX_CYC + 1);
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

  seq_state_e        state_q, state_d;
  logic [TICK_W-1:0] tick_q, tick_d, tick_last;
  logic [ROW_W-1:0]  row_q, row_d;

  always_comb begin
    tick_last = (state_q == SEQ_STORE) ? TICK_W'(STORE_ROW_CYC - 1)
                                       : TICK_W'(RECALL_ROW_CYC - 1);
    row_fire  = (state_q != SEQ_IDLE) && (tick_q == tick_last);
    state_d   = state_q;
    tick_d    = tick_q;
    row_d     = row_q;
    if (state_q == SEQ_IDLE) begin
      tick_d = '0;
      row_d  = '0;
      if (store_req) begin
        state_d = SEQ_STORE;
      end else if (recall_req) begin
        state_d = SEQ_CLEAR;
      end
    end else if (row_fire) begin
      tick_d = '0;
      row_d  = row_q + 1'b1;
      if (row_q == ROW_LAST) begin
        state_d = (state_q == SEQ_CLEAR) ? SEQ_LOAD : SEQ_IDLE;
      end
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_CLEAR;
      tick_q  <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      row_q   <= row_d;
    end
  end

  assign state   = state_q;
  assign row_sel = row_q;
  assign busy    = (state_q != SEQ_IDLE);
endmodule

// File: rtl/nvsram_port.sv
module nvsram_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              nv_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic              store_req,
  output logic              recall_req,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic              rd_hit;
  logic [DATA_W-1:0] dq_o_q;
  logic              dq_oe_q;

  always_comb begin
    rd_hit     = !busy && !ce_n && !oe_n && we_n && nv_n;
    wr_en      = !busy && !ce_n && !we_n && nv_n;
    store_req  = !ce_n && !nv_n && !we_n;
    recall_req = !ce_n && !nv_n && we_n && !oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe_q <= 1'b0;
      dq_o_q  <= '0;
    end else begin
      dq_oe_q <= rd_hit;
      if (rd_hit) begin
        dq_o_q <= rd_data;
      end
    end
  end

  assign dq_o  = dq_o_q;
  assign dq_oe = dq_oe_q;
endmodule

// File: rtl/nvsram_core.sv
module nvsram_core
  import nvsram_pkg::*;
#(
  parameter int ADDR_W         = 9,
  parameter int COL_W          = 5,
  parameter int DATA_W         = 8,
  parameter int STORE_ROW_CYC  = 64,
  parameter int RECALL_ROW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              nv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              busy
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic rst_meta_q, rst_sync_q;

  // Reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_e        state;
  logic              row_fire;
  logic [ROW_W-1:0]  row_sel;
  logic              wr_en, store_req, recall_req;
  logic [DATA_W-1:0] rd_data;

  nvsram_seq #(
    .ROW_W(ROW_W), .STORE_ROW_CYC(STORE_ROW_CYC), .RECALL_ROW_CYC(RECALL_ROW_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .store_req(store_req), .recall_req(recall_req),
    .state(state), .row_fire(row_fire), .row_sel(row_sel), .busy(busy)
  );

  nvsram_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_sync_q), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
    .busy(busy), .rd_data(rd_data), .wr_en(wr_en), .store_req(store_req),
    .recall_req(recall_req), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  nvsram_cells #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .wr_en(wr_en), .wr_addr(addr), .wr_data(dq_i), .rd_addr(addr),
    .rd_data(rd_data), .state(state), .row_fire(row_fire), .row_sel(row_sel)
  );
endmodule

// File: rtl/nvsram_chk.sv
module nvsram_chk #(
  parameter int ADDR_W         = 9,
  parameter int COL_W          = 5,
  parameter int STORE_ROW_CYC  = 64,
  parameter int RECALL_ROW_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic nv_n,
  input logic dq_oe,
  input logic busy
);
  localparam int ROWS       = 2 ** (ADDR_W - COL_W);
  localparam int STORE_LEN  = ROWS * STORE_ROW_CYC;
  localparam int RECALL_LEN = 2 * ROWS * RECALL_ROW_CYC;

  logic [31:0] run_q;
  logic        op_user_q, op_store_q;
  logic        start_req;

  assign start_req = !ce_n && !nv_n && (!we_n || !oe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      op_user_q  <= 1'b0;
      op_store_q <= 1'b0;
    end else begin
      run_q <= busy ? run_q + 32'd1 : 32'd0;
      if (!busy) begin
        op_user_q  <= start_req;
        op_store_q <= !we_n;
      end
    end
  end

  // R2
  read_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!busy && !ce_n && !oe_n && we_n && nv_n));

  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dq_oe);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));

  // R8
  transfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op_user_q) |-> (run_q == (op_store_q ? STORE_LEN : RECALL_LEN)));
endmodule

bind nvsram_core nvsram_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W),
  .STORE_ROW_CYC(STORE_ROW_CYC), .RECALL_ROW_CYC(RECALL_ROW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .nv_n(nv_n), .dq_oe(dq_oe), .busy(busy)
);

// File: tb/nvsram_core_bench.sv
module nvsram_core_bench;
  localparam int SRC   = 8;
  localparam int RRC   = 2;
  localparam int WORDS = 512;

  logic       clk, rst_n, ce_n, oe_n, we_n, nv_n, dq_oe, busy;
  logic [8:0] addr;
  logic [7:0] dq_i, dq_o;
  int checks, fails;

  nvsram_core #(.STORE_ROW_CYC(SRC), .RECALL_ROW_CYC(RRC)) u_nvsram_core (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int a, bit inv);
    logic [7:0] v;
    v = 8'(a * 29) ^ ((a >= 256) ? 8'h5A : 8'h00) ^ ((a % 64 >= 32) ? 8'h81 : 8'h00);
    return inv ? ~v : v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; nv_n = 1'b1;
  endtask

  task automatic wr(int a, logic [7:0] d, bit oe_low);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = !oe_low; nv_n = 1'b1; addr = 9'(a); dq_i = d;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic rd_chk(int a, logic [7:0] exp, string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; nv_n = 1'b1; addr = 9'(a);
    @(negedge clk);
    chk(dq_oe === 1'b1, {tag, " oe"}, int'(dq_oe), 1);
    chk(dq_o === exp, tag, int'(dq_o), int'(exp));
    bus_idle();
  endtask

  task automatic t_reset();
    int n;
    bus_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b1, "R9 busy in reset", int'(busy), 1);
    chk(dq_oe === 1'b0, "R3 dq_oe in reset", int'(dq_oe), 0);
    rst_n = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0; addr = '0;
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      if (busy) chk(dq_oe === 1'b0, "R9 read during auto recall", int'(dq_oe), 0);
      n++;
    end
    chk(busy === 1'b0, "R9 auto recall ends", int'(busy), 0);
    bus_idle();
    @(negedge clk);
  endtask

  task automatic t_fill(bit inv);
    for (int a = 0; a < WORDS; a++) begin
      wr(a, pat(a, inv), a[0]);
      if (a == 1) chk(dq_oe === 1'b0, "R3 R4 no drive on write with oe low", int'(dq_oe), 0);
    end
  endtask

  task automatic t_read_all(bit inv, string tag);
    for (int a = 0; a < WORDS; a++) rd_chk(a, pat(a, inv), tag);
  endtask

  task automatic t_bus_modes();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; nv_n = 1'b1; addr = 9'd7;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R3 unselected", int'(dq_oe), 0);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R3 internal read", int'(dq_oe), 0);
    bus_idle();
  endtask

  // Issue a transfer, then keep hitting the bus while busy
  task automatic t_transfer(bit is_store, int exp_len, string tag);
    int n;
    @(negedge clk);
    ce_n = 1'b0; nv_n = 1'b0; we_n = !is_store; oe_n = is_store; addr = 9'd5;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      if (!busy || n > 4000) break;
      n++;
      chk(dq_oe === 1'b0, "R6 no drive while busy", int'(dq_oe), 0);
      bus_idle();
      ce_n = 1'b0;
      case (n % 3)
        0: begin we_n = 1'b0; addr = 9'd5; dq_i = 8'h3C; end
        1: begin oe_n = 1'b0; addr = 9'd5; end
        default: begin
          nv_n = 1'b0;
          if (is_store) oe_n = 1'b0; else we_n = 1'b0;
        end
      endcase
    end
    bus_idle();
    chk(n == exp_len, tag, n, exp_len);
  endtask

  initial begin
    checks = 0; fails = 0;
    addr = '0; dq_i = '0;
    t_reset();
    t_fill(1'b0);
    t_read_all(1'b0, "R1 R2 R4 readback A");
    t_bus_modes();
    t_transfer(1'b1, 16 * SRC, "R5 R8 store length");
    rd_chk(5, pat(5, 1'b0), "R6 write ignored during store");
    t_fill(1'b1);
    t_read_all(1'b1, "R1 readback B");
    t_transfer(1'b0, 32 * RRC, "R7 R8 recall length");
    t_read_all(1'b0, "R7 R8 recall restores A");
    t_fill(1'b1);
    t_transfer(1'b0, 32 * RRC, "R7 second recall length");
    t_read_all(1'b0, "R7 shadow unchanged");
    t_fill(1'b1);
    t_reset();
    t_read_all(1'b0, "R9 auto recall restores A");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule